// File: doc/BRIEF.md
# Two-Channel Shared-Pin Bus Handoff Arbiter

This block sits on the processor side of a bus-sharing link. The link uses one active-low, bidirectional pin per channel. Each pin is modelled as three signals: the level read from the pin, the level driven onto it, and a drive enable. A second local master asks for the bus with a one-clock low pulse on its channel's pin. The arbiter answers on the same pin with a one-clock low grant pulse. At that point the processor's bus is floated. The bus stays released until the master sends a one-clock low release pulse. The arbiter then takes the bus back and leaves one dead clock before any new exchange can begin.

The block does not run bus cycles itself. It reads the state of the processor's current cycle and a few qualifiers, and it uses them to decide when a handoff is allowed. The qualifiers are: a low byte on an odd address, a first interrupt-acknowledge cycle, a locked instruction, and an idle bus. If the bus is idle, a request is answered on the next clock. If a memory cycle is running, the bus is given up only at the cycle's last clock, and only when nothing forbids it. Requests that cannot be honoured yet stay pending. Channel 0 wins over channel 1.

Top module: `bus_handoff_arb`

## Requirements
- R1: A grant is a single-clock low pulse on `grantOut_n` of the requesting channel only. `grantOe` is high for that channel in exactly that clock and low otherwise. Bit i of each vector belongs to channel i.
- R2: When `busIdle` is high in the clock where a request pulse arrives (or a request is pending), the grant appears in the next clock.
- R3: `busState` encodes 0 = no cycle, 1 = T1, 2 = T2, 3 = T3, 4 = wait, 5 = T4. Take a request that arrives during T1 or T2 of a running cycle (`busIdle` low). Its grant appears in the clock after that cycle's T4 clock, provided no blocking qualifier is high in the T4 clock.
- R4: A request that first arrives during T3, a wait state or T4 is not granted after that cycle's T4. It is granted after the T4 of the following cycle.
- R5: If `oddLowByte`, `firstIntAck` or `lockActive` is high in the T4 clock, no grant follows. The request stays pending and is granted one clock after the next clock in which the bus is idle, or after a clean T4.
- R6: When both channels request in the same clock, channel 0 is granted.
- R7: `busFloat` is high from the grant clock up to and including the clock in which the owner's release pulse arrives. It is low in the clock after the release.
- R8: No grant is given in the two clocks following a release clock. Request pulses that arrive in the release clock or the dead clock after it are discarded.
- R9: While one channel holds the bus (grant clock through release clock), request pulses on the other channel are discarded and never granted later.
- R10: A pin reading high carries no request. After reset, `grantOut_n` is all ones, `grantOe` is all zeros and `busFloat` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqIn_n | input | NUM_CH | Level read from each channel's pin, low = pulse from the other master |
| busState | input | 3 | Phase of the processor's current bus cycle (encoding in R3) |
| busIdle | input | 1 | High when no bus cycle is running |
| oddLowByte | input | 1 | Current cycle is the low-byte half of an odd-address word |
| firstIntAck | input | 1 | Current cycle is the first of an interrupt-acknowledge pair |
| lockActive | input | 1 | A locked instruction is executing |
| grantOut_n | output | NUM_CH | Level driven onto each channel's pin, low = grant pulse |
| grantOe | output | NUM_CH | Drive enable for each channel's pin |
| busFloat | output | 1 | High while the processor's bus outputs must float |

## Verification
The assertions assume that every request and release arrives as a single low clock on one pin. They also assume that a release comes only from the master that holds the bus, and that `busState` advances through legal cycle phases. The directed tasks keep to these rules. Each pulse is raised for exactly one step. Release pulses are sent only by the owning channel, after the grant has been seen. Cycle phases are always stepped in order T1, T2, T3, an optional wait state, then T4, or the bus is held idle.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;

  typedef enum logic [2:0] {
    BS_NONE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_TW   = 3'd4,
    BS_T4   = 3'd5
  } busPhase_e;

  typedef enum logic [1:0] {
    ST_OWN   = 2'd0,
    ST_GRANT = 2'd1,
    ST_HELD  = 2'd2,
    ST_DEAD  = 2'd3
  } handoffState_e;

  typedef struct packed {
    logic sampleEn;   // accept new request pulses into the pending set
    logic fire;       // grant decision taken this clock
    logic fromIdle;   // decision taken on an idle bus (any request eligible)
    logic driveGrant; // drive the grant pulse on the owner's pin
  } handoffStrobe_t;

endpackage

// File: rtl/bus_handoff_dp.sv
module bus_handoff_dp
  import bus_handoff_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int OWN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    reqLow,
  input  logic [2:0]           busState,
  input  logic                 busIdle,
  input  handoffStrobe_t       strobe,
  output logic                 idleAny,
  output logic                 t4Any,
  output logic                 ownerReq,
  output logic [NUM_CH-1:0]    grantLow
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] late;
  logic [NUM_CH-1:0] idleCand;
  logic [NUM_CH-1:0] t4Cand;
  logic [OWN_W-1:0]  owner;
  logic              lateWin;
  logic              newCycle;

  assign lateWin  = !busIdle && (busState == BS_T3 || busState == BS_TW || busState == BS_T4);
  assign newCycle = busIdle || (busState == BS_T1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n || strobe.fire) begin
        pend[g] <= 1'b0;
        late[g] <= 1'b0;
      end else if (strobe.sampleEn) begin
        if (reqLow[g] && !pend[g]) begin
          pend[g] <= 1'b1;
          late[g] <= lateWin;
        end else if (newCycle) begin
          late[g] <= 1'b0;
        end
      end
    end
  end

  assign idleCand = pend | reqLow;
  assign t4Cand   = pend & ~late;
  assign idleAny  = |idleCand;
  assign t4Any    = |t4Cand;

  function automatic logic [OWN_W-1:0] pickLowest(input logic [NUM_CH-1:0] v);
    pickLowest = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) pickLowest = OWN_W'(i);
    end
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= '0;
    end else if (strobe.fire) begin
      owner <= pickLowest(strobe.fromIdle ? idleCand : t4Cand);
    end
  end

  assign ownerReq = reqLow[owner];

  always_comb begin
    grantLow = '0;
    if (strobe.driveGrant) grantLow[owner] = 1'b1;
  end

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
  import bus_handoff_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     busState,
  input  logic           busIdle,
  input  logic           oddLowByte,
  input  logic           firstIntAck,
  input  logic           lockActive,
  input  logic           idleAny,
  input  logic           t4Any,
  input  logic           ownerReq,
  output handoffStrobe_t strobe,
  output logic           busFloat
);

  handoffState_e state;
  handoffState_e stateNxt;
  logic          releaseOk;
  logic          fireNow;

  assign releaseOk = !oddLowByte && !firstIntAck && !lockActive;
  assign fireNow   = (state == ST_OWN) &&
                     (busIdle ? idleAny : (busState == BS_T4 && releaseOk && t4Any));

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_OWN:   if (fireNow)  stateNxt = ST_GRANT;
      ST_GRANT:               stateNxt = ST_HELD;
      ST_HELD:  if (ownerReq) stateNxt = ST_DEAD;
      ST_DEAD:                stateNxt = ST_OWN;
      default:                stateNxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= stateNxt;
  end

  always_comb begin
    strobe.sampleEn   = (state == ST_OWN);
    strobe.fire       = fireNow;
    strobe.fromIdle   = busIdle;
    strobe.driveGrant = (state == ST_GRANT);
  end

  assign busFloat = (state == ST_GRANT) || (state == ST_HELD);

endmodule

// File: rtl/bus_handoff_arb.sv
module bus_handoff_arb
  import bus_handoff_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] reqIn_n,
  input  logic [2:0]        busState,
  input  logic              busIdle,
  input  logic              oddLowByte,
  input  logic              firstIntAck,
  input  logic              lockActive,
  output logic [NUM_CH-1:0] grantOut_n,
  output logic [NUM_CH-1:0] grantOe,
  output logic              busFloat
);

  handoffStrobe_t    strobe;
  logic              idleAny;
  logic              t4Any;
  logic              ownerReq;
  logic [NUM_CH-1:0] grantLow;

  bus_handoff_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busState   (busState),
    .busIdle    (busIdle),
    .oddLowByte (oddLowByte),
    .firstIntAck(firstIntAck),
    .lockActive (lockActive),
    .idleAny    (idleAny),
    .t4Any      (t4Any),
    .ownerReq   (ownerReq),
    .strobe     (strobe),
    .busFloat   (busFloat)
  );

  bus_handoff_dp #(.NUM_CH(NUM_CH)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqLow   (~reqIn_n),
    .busState (busState),
    .busIdle  (busIdle),
    .strobe   (strobe),
    .idleAny  (idleAny),
    .t4Any    (t4Any),
    .ownerReq (ownerReq),
    .grantLow (grantLow)
  );

  assign grantOut_n = ~grantLow;
  assign grantOe    = grantLow;

endmodule

// File: rtl/bus_handoff_chk.sv
module bus_handoff_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] reqIn_n,
  input logic [2:0]        busState,
  input logic              busIdle,
  input logic              oddLowByte,
  input logic              firstIntAck,
  input logic              lockActive,
  input logic [NUM_CH-1:0] grantOut_n,
  input logic [NUM_CH-1:0] grantOe,
  input logic              busFloat
);

  a_r1_grant_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !(&grantOut_n) |=> (&grantOut_n));

  a_r1_grant_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grantOut_n));

  a_r1_drive_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantOe));

  a_r3_grant_after_t4_or_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(&grantOut_n) |-> $past(busIdle || busState == 3'd5));

  a_r5_blocked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!busFloat && !busIdle && busState == 3'd5 && (oddLowByte || firstIntAck || lockActive))
      |=> (&grantOut_n));

  a_r7_float_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(&grantOut_n) |-> busFloat);

  a_r7_float_holds_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(&grantOut_n) |=> busFloat);

  a_r8_dead_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busFloat) |-> (&grantOut_n));

  a_r8_after_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busFloat) |=> (&grantOut_n));

endmodule

bind bus_handoff_arb bus_handoff_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqIn_n    (reqIn_n),
  .busState   (busState),
  .busIdle    (busIdle),
  .oddLowByte (oddLowByte),
  .firstIntAck(firstIntAck),
  .lockActive (lockActive),
  .grantOut_n (grantOut_n),
  .grantOe    (grantOe),
  .busFloat   (busFloat)
);

// File: tb/bus_handoff_arb_tb_top.sv
`timescale 1ns/1ps
module bus_handoff_arb_tb_top;

  localparam logic [2:0] P_NONE = 3'd0;
  localparam logic [2:0] P_T1   = 3'd1;
  localparam logic [2:0] P_T2   = 3'd2;
  localparam logic [2:0] P_T3   = 3'd3;
  localparam logic [2:0] P_TW   = 3'd4;
  localparam logic [2:0] P_T4   = 3'd5;

  localparam logic [1:0] NO_G  = 2'b11; // no grant
  localparam logic [1:0] G0    = 2'b10; // channel 0 pulse low
  localparam logic [1:0] G1    = 2'b01; // channel 1 pulse low

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reqIn_n = 2'b11;
  logic [2:0] busState = P_NONE;
  logic       busIdle = 1'b1;
  logic       oddLowByte = 1'b0;
  logic       firstIntAck = 1'b0;
  logic       lockActive = 1'b0;
  logic [1:0] grantOut_n;
  logic [1:0] grantOe;
  logic       busFloat;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  bus_handoff_arb #(.NUM_CH(2)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqIn_n    (reqIn_n),
    .busState   (busState),
    .busIdle    (busIdle),
    .oddLowByte (oddLowByte),
    .firstIntAck(firstIntAck),
    .lockActive (lockActive),
    .grantOut_n (grantOut_n),
    .grantOe    (grantOe),
    .busFloat   (busFloat)
  );

  // Apply inputs, then wait until the edge that samples them has passed.
  task automatic step(input logic [2:0] ph, input logic idle, input logic [1:0] rq);
    busState = ph;
    busIdle  = idle;
    reqIn_n  = rq;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] expG, input logic expF);
    tests++;
    if (grantOut_n !== expG || grantOe !== ~expG || busFloat !== expF) begin
      fails++;
      $display("FAIL %s: grantOut_n=%b grantOe=%b busFloat=%b, expected grantOut_n=%b grantOe=%b busFloat=%b",
               tag, grantOut_n, grantOe, busFloat, expG, ~expG, expF);
    end
  endtask

  // Owner releases; bus comes back; one dead clock with a stray request.
  task automatic finish_exchange(input string tag, input logic [1:0] relPin);
    step(P_NONE, 1'b1, 2'b11);
    expect_out({tag, " R1 single-clock grant, R7 still floating"}, NO_G, 1'b1);
    step(P_NONE, 1'b1, relPin);
    expect_out({tag, " R7 bus reclaimed after release"}, NO_G, 1'b0);
    step(P_NONE, 1'b1, 2'b00);
    expect_out({tag, " R8 dead clock ignores requests"}, NO_G, 1'b0);
    step(P_NONE, 1'b1, 2'b11);
    expect_out({tag, " R8 dead-clock request discarded"}, NO_G, 1'b0);
  endtask

  task automatic t_reset();
    expect_out("R10 reset state", NO_G, 1'b0);
  endtask

  task automatic t_undriven();
    step(P_NONE, 1'b1, 2'b11);
    step(P_NONE, 1'b1, 2'b11);
    expect_out("R10 high pin carries no request", NO_G, 1'b0);
  endtask

  task automatic t_idle_ch1();
    step(P_NONE, 1'b1, 2'b01);
    expect_out("R2 idle grant next clock on ch1 (R1)", G1, 1'b1);
    finish_exchange("idle ch1", 2'b01);
  endtask

  task automatic t_priority();
    step(P_NONE, 1'b1, 2'b00);
    expect_out("R6 channel 0 wins", G0, 1'b1);
    step(P_NONE, 1'b1, 2'b01);
    expect_out("R9 other channel ignored while held", NO_G, 1'b1);
    step(P_NONE, 1'b1, 2'b10);
    expect_out("R7 release ch0", NO_G, 1'b0);
    step(P_NONE, 1'b1, 2'b11);
    step(P_NONE, 1'b1, 2'b11);
    expect_out("R9 ignored request never granted", NO_G, 1'b0);
  endtask

  task automatic t_mem_early();
    step(P_T1, 1'b0, 2'b11);
    step(P_T2, 1'b0, 2'b10);
    expect_out("R3 no grant at T2", NO_G, 1'b0);
    step(P_T3, 1'b0, 2'b11);
    step(P_TW, 1'b0, 2'b11);
    expect_out("R3 no grant in wait", NO_G, 1'b0);
    step(P_T4, 1'b0, 2'b11);
    expect_out("R3 grant after T4", G0, 1'b1);
    finish_exchange("mem ch0", 2'b10);
  endtask

  task automatic t_mem_late();
    step(P_T1, 1'b0, 2'b11);
    step(P_T2, 1'b0, 2'b11);
    step(P_T3, 1'b0, 2'b01);
    step(P_T4, 1'b0, 2'b11);
    expect_out("R4 late request not granted this T4", NO_G, 1'b0);
    step(P_T1, 1'b0, 2'b11);
    step(P_T2, 1'b0, 2'b11);
    step(P_T3, 1'b0, 2'b11);
    expect_out("R4 still waiting", NO_G, 1'b0);
    step(P_T4, 1'b0, 2'b11);
    expect_out("R4 granted after next T4", G1, 1'b1);
    finish_exchange("late ch1", 2'b01);
  endtask

  task automatic t_blocked(input int kind, input string name);
    step(P_T1, 1'b0, 2'b11);
    step(P_T2, 1'b0, 2'b10);
    step(P_T3, 1'b0, 2'b11);
    oddLowByte  = (kind == 0);
    firstIntAck = (kind == 1);
    lockActive  = (kind == 2);
    step(P_T4, 1'b0, 2'b11);
    expect_out({"R5 blocked by ", name}, NO_G, 1'b0);
    oddLowByte  = 1'b0;
    firstIntAck = 1'b0;
    lockActive  = 1'b0;
    step(P_T1, 1'b0, 2'b11);
    expect_out({"R5 pending kept after ", name}, NO_G, 1'b0);
    step(P_NONE, 1'b1, 2'b11);
    expect_out({"R5 pending served on idle after ", name}, G0, 1'b1);
    finish_exchange({"blocked ", name}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_undriven();
    t_idle_ch1();
    t_priority();
    t_mem_early();
    t_mem_late();
    t_blocked(0, "odd low byte");
    t_blocked(1, "first int ack");
    t_blocked(2, "lock");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule